// File: doc/BRIEF.md
# Barrel Shift Unit with Condition Flags

This unit performs one shift per cycle for a small CPU datapath. A 32-bit operand is moved by a 5-bit amount in one of six modes. Three modes shift left: a logical mode, a plain arithmetic mode that reports lost sign information in its overflow flag, and an arithmetic mode that holds the sign bit in place. Three modes shift right: a logical mode, an arithmetic mode, and an arithmetic mode whose carry is chosen for rounding. The unit returns the result together with carry, overflow, zero and negative flags.

Plain arithmetic right shift divides a signed value by a power of two and rounds toward minus infinity. In the rounding-carry mode, carry is set for a negative operand that lost at least one 1 bit. The next instruction can then add that carry to the shifted value and obtain a quotient truncated toward zero. That add is done by the datapath adder and is not part of this unit.

A decoder turns the opcode and the amount into a small strobe struct. A datapath module runs a logarithmic shifter on that struct. With the default parameter `OUT_REG = 1`, results and flags are captured in a register stage. With `OUT_REG = 0`, they leave the unit combinationally.

Top module: `shift_flag_unit`

## Requirements
- R1: Opcode 0 (logical left) gives result = operand << n with zero fill. Carry is the last bit shifted out, operand[32-n]. Overflow is 0.
- R2: Opcode 2 (arithmetic left) gives the same result and carry as opcode 0. Overflow is 1 exactly when some bit shifted out, operand[31] down to operand[32-n], differs from result bit 31.
- R3: Opcode 1 (sign-holding left) gives result[31] = operand[31] and result[30:0] = (operand << n)[30:0]. Carry is operand[31-n], the last bit leaving position 30. Overflow is 0.
- R4: Opcode 3 (logical right) gives result = operand >> n with zero fill. Carry is operand[n-1]. Overflow is 0.
- R5: Opcode 4 (arithmetic right) fills vacated high bits with operand[31], so the result is the signed quotient rounded toward minus infinity. Carry is operand[n-1]. Overflow is 0.
- R6: Opcode 5 (arithmetic right, rounding carry) gives the same result as opcode 4. Carry is 1 only when operand[31] is 1 and some 1 bit was shifted out, so result + carry is the signed quotient truncated toward zero. Overflow is 0.
- R7: A shift amount of 0 returns the operand unchanged and clears carry and overflow, for every opcode.
- R8: Opcodes 6 and 7 are reserved. They return the operand unchanged and clear carry and overflow.
- R9: The zero flag is 1 exactly when the result is all zeros. The negative flag equals result bit 31.
- R10: With OUT_REG = 1, all outputs change only at a rising clock edge, one edge after the inputs are applied. The active-low asynchronous reset clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register stage |
| rstN | input | 1 | Asynchronous active-low reset |
| opIn | input | 3 | Shift mode select (codes as in R1 to R8) |
| amtIn | input | 5 | Shift distance, 0 to 31 |
| operandIn | input | 32 | Value to shift |
| resultOut | output | 32 | Shifted value |
| carryOut | output | 1 | Carry flag |
| overflowOut | output | 1 | Overflow flag |
| zeroOut | output | 1 | Result-is-zero flag |
| negOut | output | 1 | Result sign flag |

## Verification
The left modes are driven with operands just below and just above the sign boundary, such as 0x20000000, 0x40000000, 0xC0000000 and 0x80000000. These separate overflow caused by a changed sign from overflow caused by a shifted-out bit that disagrees with the result sign. The same operands show the sign-holding mode keeping bit 31 where the other left modes lose it. Odd and even negative values, along with positive values, are shifted right. This separates the floor result, the plain carry and the rounding carry, and each right-shift case is checked to add up to a quotient truncated toward zero. A sweep of pseudo-random operands over every opcode and every amount from 0 to 31 exercises the full shifter tree and the amount-zero and reserved-code paths.

// File: rtl/shift_pkg.sv
package shift_pkg;

  localparam int DATA_W = 32;
  localparam int AMT_W  = $clog2(DATA_W);

  typedef enum logic [2:0] {
    OP_LSL      = 3'd0,
    OP_ASL_HOLD = 3'd1,
    OP_ASL      = 3'd2,
    OP_LSR      = 3'd3,
    OP_ASR      = 3'd4,
    OP_ASR_RND  = 3'd5,
    OP_RSV6     = 3'd6,
    OP_RSV7     = 3'd7
  } shiftOp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic dirLeft;    // mirror operand so the right shifter moves left
    logic fillSign;   // fill vacated bits with operand MSB
    logic keepMsb;    // hold result MSB at operand MSB
    logic ovfEn;      // report lost sign information
    logic roundCarry; // carry = negative and sticky
    logic bypass;     // pass operand, clear carry and overflow
  } shiftCtrl_t;

  function automatic logic [DATA_W-1:0] mirror(input logic [DATA_W-1:0] v);
    logic [DATA_W-1:0] m;
    for (int i = 0; i < DATA_W; i++) m[i] = v[DATA_W-1-i];
    return m;
  endfunction

endpackage

// File: rtl/shift_ctrl.sv
module shift_ctrl
  import shift_pkg::*;
(
  input  logic [2:0]       opIn,
  input  logic [AMT_W-1:0] amtIn,
  output shiftCtrl_t       ctrlOut
);

  logic amtZero;
  assign amtZero = (amtIn == '0);

  always_comb begin
    ctrlOut = '0;
    unique case (shiftOp_e'(opIn))
      OP_LSL:      ctrlOut.dirLeft = 1'b1;
      OP_ASL_HOLD: begin
        ctrlOut.dirLeft = 1'b1;
        ctrlOut.keepMsb = 1'b1;
      end
      OP_ASL: begin
        ctrlOut.dirLeft = 1'b1;
        ctrlOut.ovfEn   = 1'b1;
      end
      OP_LSR:      ;
      OP_ASR:      ctrlOut.fillSign = 1'b1;
      OP_ASR_RND: begin
        ctrlOut.fillSign   = 1'b1;
        ctrlOut.roundCarry = 1'b1;
      end
      default:     ctrlOut.bypass = 1'b1;
    endcase
    if (amtZero) ctrlOut.bypass = 1'b1;
  end

endmodule

// File: rtl/shift_datapath.sv
module shift_datapath
  import shift_pkg::*;
#(
  parameter int W  = DATA_W,
  parameter int AW = $clog2(W)
)(
  input  shiftCtrl_t     ctrlIn,
  input  logic [AW-1:0]  amtIn,
  input  logic [W-1:0]   operandIn,
  output logic [W-1:0]   resultOut,
  output logic           carryOut,
  output logic           ovfOut
);

  localparam int STAGES = AW;

  logic [W-1:0] frameIn;
  logic         fillBit;
  logic [W-1:0] dataStg [STAGES+1];
  logic [W-1:0] maskStg [STAGES+1];

  assign frameIn    = ctrlIn.dirLeft ? mirror(operandIn) : operandIn;
  assign fillBit    = ctrlIn.fillSign & operandIn[W-1];
  assign dataStg[0] = frameIn;
  assign maskStg[0] = '1;

  // logarithmic right shifter; a parallel ones-vector tracks kept positions
  generate
    for (genvar k = 0; k < STAGES; k++) begin : g_stage
      localparam int D = 2 ** k;
      assign dataStg[k+1] = amtIn[k] ? {{D{fillBit}}, dataStg[k][W-1:D]} : dataStg[k];
      assign maskStg[k+1] = amtIn[k] ? {{D{1'b0}},    maskStg[k][W-1:D]} : maskStg[k];
    end
  endgenerate

  logic [W-1:0] shifted;
  logic [W-1:0] lostMask;   // frame positions that left the word
  logic [W-1:0] shapedRes;
  logic         sticky;
  logic         lastOut;
  logic         signDiff;
  logic [AW-1:0] amtDec;

  assign shifted   = ctrlIn.dirLeft ? mirror(dataStg[STAGES]) : dataStg[STAGES];
  assign lostMask  = ~mirror(maskStg[STAGES]);
  assign shapedRes = ctrlIn.keepMsb ? {operandIn[W-1], shifted[W-2:0]} : shifted;
  assign sticky    = |(frameIn & lostMask);
  assign amtDec    = amtIn - 1'b1;
  assign lastOut   = ctrlIn.keepMsb ? frameIn[amtIn] : frameIn[amtDec];
  assign signDiff  = |((frameIn ^ {W{shapedRes[W-1]}}) & lostMask);

  always_comb begin
    if (ctrlIn.bypass) begin
      resultOut = operandIn;
      carryOut  = 1'b0;
      ovfOut    = 1'b0;
    end else begin
      resultOut = shapedRes;
      carryOut  = ctrlIn.roundCarry ? (operandIn[W-1] & sticky) : lastOut;
      ovfOut    = ctrlIn.ovfEn & signDiff;
    end
  end

endmodule

// File: rtl/shift_flag_unit.sv
module shift_flag_unit
  import shift_pkg::*;
#(
  parameter int W       = DATA_W,
  parameter int OUT_REG = 1
)(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [2:0]           opIn,
  input  logic [$clog2(W)-1:0] amtIn,
  input  logic [W-1:0]         operandIn,
  output logic [W-1:0]         resultOut,
  output logic                 carryOut,
  output logic                 overflowOut,
  output logic                 zeroOut,
  output logic                 negOut
);

  localparam int AW = $clog2(W);

  shiftCtrl_t   ctrl;
  logic [W-1:0] dpResult;
  logic         dpCarry;
  logic         dpOvf;
  logic         dpZero;
  logic         dpNeg;

  shift_ctrl u_ctrl (
    .opIn    (opIn),
    .amtIn   (amtIn),
    .ctrlOut (ctrl)
  );

  shift_datapath #(.W(W), .AW(AW)) u_dp (
    .ctrlIn    (ctrl),
    .amtIn     (amtIn),
    .operandIn (operandIn),
    .resultOut (dpResult),
    .carryOut  (dpCarry),
    .ovfOut    (dpOvf)
  );

  assign dpZero = (dpResult == '0);
  assign dpNeg  = dpResult[W-1];

  generate
    if (OUT_REG != 0) begin : g_reg
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          resultOut   <= '0;
          carryOut    <= 1'b0;
          overflowOut <= 1'b0;
          zeroOut     <= 1'b0;
          negOut      <= 1'b0;
        end else begin
          resultOut   <= dpResult;
          carryOut    <= dpCarry;
          overflowOut <= dpOvf;
          zeroOut     <= dpZero;
          negOut      <= dpNeg;
        end
      end

      // R10
      reg_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
        $past(rstN) |-> (resultOut == $past(dpResult)) && (carryOut == $past(dpCarry)));
    end else begin : g_comb
      assign resultOut   = dpResult;
      assign carryOut    = dpCarry;
      assign overflowOut = dpOvf;
      assign zeroOut     = dpZero;
      assign negOut      = dpNeg;
    end
  endgenerate

  // R7
  zero_amt_chk: assert property (@(posedge clk) disable iff (!rstN)
    (amtIn == '0) |-> (dpResult == operandIn) && !dpCarry && !dpOvf);

  // R3
  hold_sign_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opIn == 3'd1) |-> (dpResult[W-1] == operandIn[W-1]) && !dpOvf);

  // R1
  lsl_no_ovf_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opIn == 3'd0) |-> !dpOvf);

  // R5
  asr_sign_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opIn == 3'd4) |-> (dpResult[W-1] == operandIn[W-1]));

  // R6
  rnd_carry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opIn == 3'd5) && dpCarry |-> operandIn[W-1] && (amtIn != '0));

  // R8
  reserved_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opIn[2:1] == 2'b11) |-> (dpResult == operandIn) && !dpCarry && !dpOvf);

endmodule

// File: tb/sim_shift_flag_unit.sv
module sim_shift_flag_unit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  opIn = '0;
  logic [4:0]  amtIn = '0;
  logic [31:0] operandIn = '0;
  logic [31:0] resultOut;
  logic        carryOut, overflowOut, zeroOut, negOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  shift_flag_unit u0 (
    .clk(clk), .rstN(rstN), .opIn(opIn), .amtIn(amtIn), .operandIn(operandIn),
    .resultOut(resultOut), .carryOut(carryOut), .overflowOut(overflowOut),
    .zeroOut(zeroOut), .negOut(negOut)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h expected=%h", tag, got, exp);
    end
  endtask

  // independent reference built from the requirement text
  task automatic model(input logic [2:0] op, input logic [4:0] n, input logic [31:0] a,
                       output logic [31:0] r, output logic c, output logic v);
    logic [63:0] wide;
    r = a; c = 1'b0; v = 1'b0;
    if (n == 0 || op > 3'd5) return;
    if (op <= 3'd2) begin
      wide = {32'b0, a} << n;
      r = wide[31:0];
      c = wide[32];
      if (op == 3'd2)
        for (int i = 0; i < 32; i++) if (i < n && a[31-i] != r[31]) v = 1'b1;
      if (op == 3'd1) begin
        r[31] = a[31];
        c = a[31-n];
      end
    end else if (op == 3'd3) begin
      wide = {a, 32'b0} >> n;
      r = wide[63:32];
      c = wide[31];
    end else begin
      wide = $signed({a, 32'b0}) >>> n;
      r = wide[63:32];
      c = wide[31];
      if (op == 3'd5) c = a[31] & (wide[31:0] != 0);
    end
  endtask

  // drive at a falling edge, sample at the next falling edge (one register)
  task automatic run(input logic [2:0] op, input logic [4:0] n, input logic [31:0] a);
    @(negedge clk);
    opIn = op; amtIn = n; operandIn = a;
    @(negedge clk);
  endtask

  task automatic cmpModel(input string tag, input logic [2:0] op, input logic [4:0] n,
                          input logic [31:0] a);
    logic [31:0] r; logic c, v;
    model(op, n, a, r, c, v);
    run(op, n, a);
    chk({tag, " result"}, resultOut, r);
    chk({tag, " carry"}, 32'(carryOut), 32'(c));
    chk({tag, " ovf"}, 32'(overflowOut), 32'(v));
  endtask

  task automatic testReset();
    chk("R10 reset result", resultOut, 32'h0);
    chk("R10 reset flags", {28'b0, carryOut, overflowOut, zeroOut, negOut}, 32'h0);
  endtask

  task automatic testLogicalLeft();
    run(3'd0, 5'd4, 32'hF000_000F);
    chk("R1 lsl result", resultOut, 32'h0000_00F0);
    chk("R1 lsl carry", 32'(carryOut), 32'd1);
    chk("R1 lsl ovf", 32'(overflowOut), 32'd0);
  endtask

  task automatic testArithLeft();
    run(3'd2, 5'd1, 32'h4000_0000);
    chk("R2 sign flip ovf", 32'(overflowOut), 32'd1);
    chk("R2 sign flip result", resultOut, 32'h8000_0000);
    run(3'd2, 5'd1, 32'h2000_0000);
    chk("R2 safe ovf", 32'(overflowOut), 32'd0);
    run(3'd2, 5'd1, 32'hC000_0000);
    chk("R2 neg safe ovf", 32'(overflowOut), 32'd0);
    chk("R2 neg safe carry", 32'(carryOut), 32'd1);
    run(3'd2, 5'd1, 32'h8000_0000);
    chk("R2 lost sign ovf", 32'(overflowOut), 32'd1);
    chk("R2 lost sign result", resultOut, 32'h0);
  endtask

  task automatic testHoldSign();
    run(3'd1, 5'd1, 32'h4000_0001);
    chk("R3 hold result", resultOut, 32'h0000_0002);
    chk("R3 hold carry", 32'(carryOut), 32'd1);
    chk("R3 hold ovf", 32'(overflowOut), 32'd0);
    run(3'd1, 5'd2, 32'h8000_0003);
    chk("R3 hold neg result", resultOut, 32'h8000_000C);
    chk("R3 hold neg carry", 32'(carryOut), 32'd0);
  endtask

  task automatic testRight();
    run(3'd3, 5'd1, 32'hFFFF_FFF9);
    chk("R4 lsr result", resultOut, 32'h7FFF_FFFC);
    chk("R4 lsr carry", 32'(carryOut), 32'd1);
    run(3'd4, 5'd1, 32'hFFFF_FFF9);        // -7 -> -4 (floor)
    chk("R5 asr floor", resultOut, 32'hFFFF_FFFC);
    chk("R5 asr carry", 32'(carryOut), 32'd1);
  endtask

  task automatic testRoundCarry();
    run(3'd5, 5'd1, 32'hFFFF_FFF9);        // -7/2 -> -3 truncated
    chk("R6 rnd odd neg", resultOut + 32'(carryOut), 32'hFFFF_FFFD);
    run(3'd5, 5'd1, 32'hFFFF_FFF8);        // -8/2 exact
    chk("R6 rnd even neg carry", 32'(carryOut), 32'd0);
    run(3'd5, 5'd1, 32'h0000_0007);        // positive: no correction
    chk("R6 rnd pos carry", 32'(carryOut), 32'd0);
    chk("R6 rnd pos result", resultOut, 32'h3);
    run(3'd5, 5'd4, 32'hFFFF_FF01);        // -255/16 -> -15
    chk("R6 rnd wide", resultOut + 32'(carryOut), 32'hFFFF_FFF1);
  endtask

  task automatic testZeroAmt();
    for (int op = 0; op < 8; op++) cmpModel("R7 zero amount", 3'(op), 5'd0, 32'hC000_0001);
  endtask

  task automatic testReserved();
    cmpModel("R8 reserved 6", 3'd6, 5'd7, 32'h8123_4567);
    cmpModel("R8 reserved 7", 3'd7, 5'd31, 32'h0000_0001);
  endtask

  task automatic testFlags();
    run(3'd3, 5'd31, 32'h7FFF_FFFF);
    chk("R9 zero set", 32'(zeroOut), 32'd1);
    chk("R9 neg clear", 32'(negOut), 32'd0);
    run(3'd4, 5'd31, 32'h8000_0000);
    chk("R9 neg set", 32'(negOut), 32'd1);
    chk("R9 zero clear", 32'(zeroOut), 32'd0);
  endtask

  task automatic testLatency();
    run(3'd0, 5'd1, 32'h1);
    @(negedge clk);
    opIn = 3'd0; amtIn = 5'd2; operandIn = 32'h1;
    #1;
    chk("R10 holds before edge", resultOut, 32'h2);
    @(negedge clk);
    chk("R10 updates after edge", resultOut, 32'h4);
  endtask

  task automatic sweep();
    logic [31:0] lfsr = 32'hACE1_1234;
    string tags [6] = '{"R1 sweep", "R3 sweep", "R2 sweep", "R4 sweep", "R5 sweep", "R6 sweep"};
    for (int op = 0; op < 6; op++) begin
      for (int n = 0; n < 32; n++) begin
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        cmpModel(tags[op], 3'(op), 5'(n), lfsr);
      end
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #20;
    testReset();
    @(negedge clk);
    rstN = 1'b1;
    testLogicalLeft();
    testArithLeft();
    testHoldSign();
    testRight();
    testRoundCarry();
    testZeroAmt();
    testReserved();
    testFlags();
    testLatency();
    sweep();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule